// File: doc/BRIEF.md
# Fully Associative Page Translation Buffer

This block holds a small set of recent virtual-to-physical page translations so that most memory accesses skip the page table walk. Each slot stores a virtual page number, a physical page number and a valid flag. A lookup compares the requested virtual page number against every valid slot at once. In the same cycle it returns a hit flag, the physical page number and the physical address, which is the physical page number with the untranslated page offset appended below it.

A lookup is either a demand access or a prefetch. When a demand lookup misses, the block raises a miss output so that an external table walker can fetch the translation and write it in. When a prefetch lookup misses, the block raises a drop indication instead, and no fill is requested. Only privileged (kernel) mode may change the translation state, through a write port and a flush input. The same request made in user mode has no effect and is reported as a protection fault. Victims are chosen by a binary-tree pseudo-LRU scheme.

Top module: `xlate_buf`

## Requirements
- R1: `lk_hit` is 1 in the same cycle exactly when `lk_valid` is 1 and some valid slot holds a virtual page number equal to `lk_vpn`. Prefetch and demand lookups hit in the same way.
- R2: On a hit, `lk_ppn` equals the physical page number of the matching slot. Otherwise `lk_ppn` is zero.
- R3: On a hit, `lk_paddr` equals `{lk_ppn, lk_off}`, with the offset in the low OFF_W bits. On a miss it is zero.
- R4: `lk_miss` is 1 exactly when a demand lookup (`lk_valid`=1, `lk_prefetch`=0) misses, in the same cycle.
- R5: A prefetch lookup (`lk_prefetch`=1) that misses raises `lk_drop` and never `lk_miss`. A prefetch hit leaves the replacement state unchanged.
- R6: When `priv_kernel`=0, `wr_en` and `flush` change no slot. In that cycle `prot_fault` is 1 if either input is 1, and otherwise it is 0.
- R7: A kernel write (`wr_en`=1, `priv_kernel`=1, `flush`=0) takes effect at the next rising edge. The slot it uses is chosen in this order: the slot that already holds `wr_vpn` (it is overwritten, so no duplicate is made), else the lowest-index invalid slot, else the pseudo-LRU victim.
- R8: The replacement state is an N-1 bit tree. Node k has children 2k+1 (bit 0) and 2k+2 (bit 1), and the victim is found by following the node bits from the root. Using slot w sets each node on its path to point away from w. This is applied on every demand hit and every accepted write. The victim used by a write is taken from the tree state before that cycle's updates.
- R9: Reset clears every valid flag and sets every tree bit to 0, so that all lookups miss and the first victim is slot 0.
- R10: A kernel flush (`flush`=1, `priv_kernel`=1) invalidates all slots at the next edge. It overrides a write in the same cycle and leaves the tree bits as they are.
- R11: When a demand hit and an accepted write occur in the same cycle, the tree is updated for the hit slot first and then for the written slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_prefetch | input | 1 | 1 = prefetch lookup, 0 = demand lookup |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_off | input | OFF_W | Page offset, passed through untranslated |
| priv_kernel | input | 1 | 1 = kernel mode, 0 = user mode |
| wr_en | input | 1 | Write a translation |
| wr_vpn | input | VPN_W | Virtual page number to write |
| wr_ppn | input | PPN_W | Physical page number to write |
| flush | input | 1 | Invalidate all slots |
| lk_hit | output | 1 | Lookup hit |
| lk_miss | output | 1 | Demand lookup missed; a fill is wanted |
| lk_drop | output | 1 | Prefetch lookup missed and was dropped |
| lk_ppn | output | PPN_W | Translated physical page number |
| lk_paddr | output | PPN_W+OFF_W | Translated physical address |
| prot_fault | output | 1 | Write or flush attempted in user mode |

## Verification
The lookup outputs `lk_hit`, `lk_miss`, `lk_drop`, `lk_ppn` and `lk_paddr`, together with `prot_fault`, are combinational and are due in the same cycle as the inputs that cause them. The bench therefore drives inputs just after a rising edge and compares these outputs at the following falling edge. Writes, flushes and tree updates become visible only from the cycle after the next rising edge. The behavioural model in the bench updates its own state at that same edge, so each later lookup is compared against the model's state after the edge. Directed sequences pin down the eviction order, overwriting a slot that holds the same page, the override of a write by a flush, and the refusal of writes and flushes in user mode. A long randomised phase then compares every output on every cycle.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  // Action taken on the translation state in a given cycle
  typedef enum logic [1:0] {
    WA_NONE   = 2'd0,
    WA_FLUSH  = 2'd1,
    WA_FILL   = 2'd2,
    WA_REFUSE = 2'd3
  } wr_act_e;

endpackage

// File: rtl/xlate_entry_array.sv
module xlate_entry_array #(
  parameter int N     = 8,
  parameter int VPN_W = 20,
  parameter int PPN_W = 18,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] cmp_vpn,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             flush_en,
  output logic [N-1:0]     valid_vec,
  output logic [N-1:0]     hit_vec,
  output logic [N-1:0]     wmatch_vec,
  output logic [PPN_W-1:0] rd_ppn
);

  logic [N-1:0]     valid_q;
  logic [N-1:0]     valid_d;
  logic [PPN_W-1:0] ppn_masked [N];

  // next state of the valid flags
  always_comb begin
    valid_d = valid_q;
    if (flush_en) begin
      valid_d = '0;
    end else if (wr_en) begin
      valid_d[wr_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_d;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic [VPN_W-1:0] vpn_r;
    logic [PPN_W-1:0] ppn_r;
    logic             slot_we;

    assign slot_we = wr_en && !flush_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (slot_we) begin
        vpn_r <= wr_vpn;
        ppn_r <= wr_ppn;
      end
    end

    assign hit_vec[g]    = valid_q[g] && (vpn_r == cmp_vpn);
    assign wmatch_vec[g] = valid_q[g] && (vpn_r == wr_vpn);
    assign ppn_masked[g] = hit_vec[g] ? ppn_r : '0;
  end

  // or-reduce: at most one slot matches
  always_comb begin
    rd_ppn = '0;
    for (int i = 0; i < N; i++) begin
      rd_ppn = rd_ppn | ppn_masked[i];
    end
  end

  assign valid_vec = valid_q;

endmodule

// File: rtl/xlate_plru.sv
module xlate_plru #(
  parameter int N = 8,
  localparam int IDX_W = $clog2(N),
  localparam int NB    = N - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_touch,
  input  logic [IDX_W-1:0] hit_idx,
  input  logic             fill_touch,
  input  logic [IDX_W-1:0] fill_idx,
  output logic [IDX_W-1:0] victim_idx
);

  logic [NB-1:0] tree_q;
  logic [NB-1:0] tree_d;
  int            vnode;

  // point every node on the path of slot w away from it
  function automatic logic [NB-1:0] touch(input logic [NB-1:0] t,
                                          input logic [IDX_W-1:0] w);
    logic [NB-1:0] r;
    int            node;
    r    = t;
    node = 0;
    for (int l = 0; l < IDX_W; l++) begin
      r[node] = ~w[IDX_W-1-l];
      node    = 2 * node + 1 + int'(w[IDX_W-1-l]);
    end
    return r;
  endfunction

  always_comb begin
    vnode = 0;
    for (int l = 0; l < IDX_W; l++) begin
      vnode = 2 * vnode + 1 + int'(tree_q[vnode]);
    end
    victim_idx = IDX_W'(vnode - NB);
  end

  always_comb begin
    tree_d = tree_q;
    if (hit_touch) begin
      tree_d = touch(tree_d, hit_idx);
    end
    if (fill_touch) begin
      tree_d = touch(tree_d, fill_idx);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tree_q <= '0;
    end else begin
      tree_q <= tree_d;
    end
  end

endmodule

// File: rtl/xlate_alloc.sv
module xlate_alloc #(
  parameter int N = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     valid_vec,
  input  logic [N-1:0]     wmatch_vec,
  input  logic [IDX_W-1:0] victim_idx,
  output logic [IDX_W-1:0] tgt_idx
);

  logic [IDX_W-1:0] match_idx;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;

  always_comb begin
    match_idx = '0;
    free_idx  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (wmatch_vec[i]) begin
        match_idx = IDX_W'(i);
      end
      if (!valid_vec[i]) begin
        free_idx = IDX_W'(i);
      end
    end
  end

  assign any_free = ~&valid_vec;

  always_comb begin
    if (|wmatch_vec) begin
      tgt_idx = match_idx;
    end else if (any_free) begin
      tgt_idx = free_idx;
    end else begin
      tgt_idx = victim_idx;
    end
  end

endmodule

// File: rtl/xlate_buf.sv
module xlate_buf #(
  parameter int N     = 8,
  parameter int VPN_W = 20,
  parameter int PPN_W = 18,
  parameter int OFF_W = 12,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_valid,
  input  logic                   lk_prefetch,
  input  logic [VPN_W-1:0]       lk_vpn,
  input  logic [OFF_W-1:0]       lk_off,
  input  logic                   priv_kernel,
  input  logic                   wr_en,
  input  logic [VPN_W-1:0]       wr_vpn,
  input  logic [PPN_W-1:0]       wr_ppn,
  input  logic                   flush,
  output logic                   lk_hit,
  output logic                   lk_miss,
  output logic                   lk_drop,
  output logic [PPN_W-1:0]       lk_ppn,
  output logic [PPN_W+OFF_W-1:0] lk_paddr,
  output logic                   prot_fault
);

  import xlate_pkg::*;

  wr_act_e          act;
  logic [N-1:0]     valid_vec;
  logic [N-1:0]     hit_vec;
  logic [N-1:0]     wmatch_vec;
  logic [PPN_W-1:0] rd_ppn;
  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W-1:0] victim_idx;
  logic [IDX_W-1:0] tgt_idx;
  logic             fill_en;
  logic             flush_en;
  logic             demand_hit;

  // privilege gate on the state-changing requests
  always_comb begin
    if (!(wr_en || flush)) begin
      act = WA_NONE;
    end else if (!priv_kernel) begin
      act = WA_REFUSE;
    end else if (flush) begin
      act = WA_FLUSH;
    end else begin
      act = WA_FILL;
    end
  end

  assign fill_en    = (act == WA_FILL);
  assign flush_en   = (act == WA_FLUSH);
  assign prot_fault = (act == WA_REFUSE);

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) begin
        hit_idx = IDX_W'(i);
      end
    end
  end

  assign lk_hit     = lk_valid && (|hit_vec);
  assign lk_miss    = lk_valid && !lk_hit && !lk_prefetch;
  assign lk_drop    = lk_valid && !lk_hit && lk_prefetch;
  assign demand_hit = lk_hit && !lk_prefetch;
  assign lk_ppn     = lk_hit ? rd_ppn : '0;
  assign lk_paddr   = lk_hit ? {rd_ppn, lk_off} : '0;

  xlate_entry_array #(
    .N    (N),
    .VPN_W(VPN_W),
    .PPN_W(PPN_W)
  ) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_vpn   (lk_vpn),
    .wr_en     (fill_en),
    .wr_idx    (tgt_idx),
    .wr_vpn    (wr_vpn),
    .wr_ppn    (wr_ppn),
    .flush_en  (flush_en),
    .valid_vec (valid_vec),
    .hit_vec   (hit_vec),
    .wmatch_vec(wmatch_vec),
    .rd_ppn    (rd_ppn)
  );

  xlate_alloc #(
    .N(N)
  ) u_alloc (
    .valid_vec (valid_vec),
    .wmatch_vec(wmatch_vec),
    .victim_idx(victim_idx),
    .tgt_idx   (tgt_idx)
  );

  xlate_plru #(
    .N(N)
  ) u_plru (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_touch (demand_hit),
    .hit_idx   (hit_idx),
    .fill_touch(fill_en),
    .fill_idx  (tgt_idx),
    .victim_idx(victim_idx)
  );

endmodule

// File: rtl/xlate_buf_chk.sv
module xlate_buf_chk #(
  parameter int N     = 8,
  parameter int PPN_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             lk_prefetch,
  input logic             priv_kernel,
  input logic             wr_en,
  input logic             flush,
  input logic             lk_hit,
  input logic             lk_miss,
  input logic             lk_drop,
  input logic [PPN_W-1:0] lk_ppn,
  input logic             prot_fault,
  input logic [N-1:0]     ent_valid,
  input logic [N-1:0]     ent_hit
);

  assert_hit_has_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_valid);

  assert_ppn_zero_on_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_ppn == '0));

  assert_miss_is_demand_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (lk_valid && !lk_prefetch && !lk_hit));

  assert_drop_is_prefetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_drop |-> (lk_prefetch && !lk_miss && !lk_hit));

  assert_user_state_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !priv_kernel |=> $stable(ent_valid));

  assert_fault_only_user_R6: assert property (@(posedge clk) disable iff (!rst_n)
    prot_fault |-> (!priv_kernel && (wr_en || flush)));

  assert_no_duplicate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ent_hit));

  assert_fill_sets_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && priv_kernel && !flush) |=> (ent_valid != '0));

  assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && priv_kernel) |=> (ent_valid == '0));

endmodule

bind xlate_buf xlate_buf_chk #(
  .N    (N),
  .PPN_W(PPN_W)
) u_xlate_buf_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_valid   (lk_valid),
  .lk_prefetch(lk_prefetch),
  .priv_kernel(priv_kernel),
  .wr_en      (wr_en),
  .flush      (flush),
  .lk_hit     (lk_hit),
  .lk_miss    (lk_miss),
  .lk_drop    (lk_drop),
  .lk_ppn     (lk_ppn),
  .prot_fault (prot_fault),
  .ent_valid  (valid_vec),
  .ent_hit    (hit_vec)
);

// File: tb/test_xlate_buf.sv
`timescale 1ns/1ps
module test_xlate_buf;

  localparam int N     = 8;
  localparam int VPN_W = 20;
  localparam int PPN_W = 18;
  localparam int OFF_W = 12;
  localparam int NB    = N - 1;
  localparam int LV    = 3;

  logic                   clk;
  logic                   rst_n;
  logic                   lk_valid;
  logic                   lk_prefetch;
  logic [VPN_W-1:0]       lk_vpn;
  logic [OFF_W-1:0]       lk_off;
  logic                   priv_kernel;
  logic                   wr_en;
  logic [VPN_W-1:0]       wr_vpn;
  logic [PPN_W-1:0]       wr_ppn;
  logic                   flush;
  logic                   lk_hit;
  logic                   lk_miss;
  logic                   lk_drop;
  logic [PPN_W-1:0]       lk_ppn;
  logic [PPN_W+OFF_W-1:0] lk_paddr;
  logic                   prot_fault;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  xlate_buf #(
    .N(N), .VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W)
  ) i_xlate_buf (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_prefetch(lk_prefetch),
    .lk_vpn(lk_vpn), .lk_off(lk_off), .priv_kernel(priv_kernel), .wr_en(wr_en),
    .wr_vpn(wr_vpn), .wr_ppn(wr_ppn), .flush(flush), .lk_hit(lk_hit),
    .lk_miss(lk_miss), .lk_drop(lk_drop), .lk_ppn(lk_ppn), .lk_paddr(lk_paddr),
    .prot_fault(prot_fault)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit               m_val  [N];
  logic [VPN_W-1:0] m_vpn  [N];
  logic [PPN_W-1:0] m_ppn  [N];
  bit               m_tree [NB];

  function automatic int m_find(input logic [VPN_W-1:0] v);
    for (int i = 0; i < N; i++) begin
      if (m_val[i] && m_vpn[i] == v) return i;
    end
    return -1;
  endfunction

  function automatic int m_victim();
    int n = 0;
    for (int l = 0; l < LV; l++) begin
      n = 2 * n + 1 + (m_tree[n] ? 1 : 0);
    end
    return n - NB;
  endfunction

  task automatic m_touch(input int w);
    int n = 0;
    for (int l = 0; l < LV; l++) begin
      int d;
      d = (w >> (LV - 1 - l)) & 1;
      m_tree[n] = (d == 0);
      n = 2 * n + 1 + d;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_val[i] = 0;
      for (int i = 0; i < NB; i++) m_tree[i] = 0;
    end else begin
      int h;
      int v;
      int t;
      bit filled;
      h = (lk_valid && !lk_prefetch) ? m_find(lk_vpn) : -1;
      v = m_victim();
      filled = 0;
      t = -1;
      if (priv_kernel && flush) begin
        for (int i = 0; i < N; i++) m_val[i] = 0;
      end else if (priv_kernel && wr_en) begin
        t = m_find(wr_vpn);
        if (t < 0) begin
          for (int i = N - 1; i >= 0; i--) if (!m_val[i]) t = i;
        end
        if (t < 0) t = v;
        m_val[t] = 1;
        m_vpn[t] = wr_vpn;
        m_ppn[t] = wr_ppn;
        filled = 1;
      end
      if (h >= 0) m_touch(h);    // R11: hit first
      if (filled) m_touch(t);
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      int  h;
      bit  eh;
      logic [PPN_W-1:0] ep;
      h  = lk_valid ? m_find(lk_vpn) : -1;
      eh = (h >= 0);
      ep = '0;
      if (eh) ep = m_ppn[h];
      chk("R1 hit", 64'(lk_hit), 64'(eh));
      chk("R2 ppn", 64'(lk_ppn), 64'(ep));
      chk("R3 paddr", 64'(lk_paddr), eh ? 64'({ep, lk_off}) : 64'd0);
      chk("R4 miss", 64'(lk_miss), 64'(lk_valid && !eh && !lk_prefetch));
      chk("R5 drop", 64'(lk_drop), 64'(lk_valid && !eh && lk_prefetch));
      chk("R6 fault", 64'(prot_fault), 64'((wr_en || flush) && !priv_kernel));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    lk_valid = 0; lk_prefetch = 0; lk_vpn = '0; lk_off = '0;
    wr_en = 0; wr_vpn = '0; wr_ppn = '0; flush = 0; priv_kernel = 1;
  endtask

  task automatic do_wr(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p,
                       input bit kern, input bit en, input bit fl);
    wr_en = en; wr_vpn = v; wr_ppn = p; flush = fl; priv_kernel = kern;
    step();
    idle();
  endtask

  task automatic look(input string tag, input logic [VPN_W-1:0] v, input bit pf,
                      input logic [OFF_W-1:0] off, input bit exp_hit,
                      input logic [PPN_W-1:0] exp_ppn);
    lk_valid = 1; lk_vpn = v; lk_prefetch = pf; lk_off = off;
    @(negedge clk);
    chk(tag, 64'(lk_hit), 64'(exp_hit));
    if (exp_hit) chk(tag, 64'(lk_ppn), 64'(exp_ppn));
    else chk(tag, pf ? 64'(lk_drop) : 64'(lk_miss), 64'd1);
    step();
    idle();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    rst_n = 0;
    idle();
    repeat (3) step();
    rst_n = 1;
    step();

    // R9: empty after reset
    look("R9 empty after reset", 20'h00100, 0, 12'h0, 0, '0);

    // R7: fill eight slots
    for (int i = 0; i < N; i++) do_wr(20'h00100 + 20'(i), 18'h03000 + 18'(i), 1, 1, 0);
    for (int i = 0; i < N; i++) look("R7 filled slot", 20'h00100 + 20'(i), 0, 12'h0, 1, 18'h03000 + 18'(i));

    // R8: tree now all zero; demand hit on slot 0 makes slot 4 the victim
    look("R8 touch slot0", 20'h00100, 0, 12'h0, 1, 18'h03000);
    do_wr(20'h00200, 18'h00001, 1, 1, 0);
    look("R8 victim evicted", 20'h00104, 0, 12'h0, 0, '0);
    look("R8 new entry", 20'h00200, 0, 12'h0, 1, 18'h00001);
    look("R8 touched kept", 20'h00100, 0, 12'h0, 1, 18'h03000);

    // R7: same VPN overwrites in place
    do_wr(20'h00105, 18'h2AAAA, 1, 1, 0);
    look("R7 overwrite", 20'h00105, 0, 12'h0, 1, 18'h2AAAA);
    look("R7 neighbour kept", 20'h00107, 0, 12'h0, 1, 18'h03007);

    // R3: offset appended
    look("R3 paddr", 20'h00200, 0, 12'hABC, 1, 18'h00001);
    lk_valid = 1; lk_vpn = 20'h00200; lk_off = 12'h5A5;
    @(negedge clk);
    chk("R3 paddr value", 64'(lk_paddr), 64'({18'h00001, 12'h5A5}));
    step();
    idle();

    // R5: prefetch miss dropped, prefetch hit fine
    look("R5 prefetch drop", 20'h00999, 1, 12'h0, 0, '0);
    look("R5 prefetch hit", 20'h00106, 1, 12'h0, 1, 18'h03006);

    // R6: user-mode write and flush refused
    wr_en = 1; wr_vpn = 20'h00300; wr_ppn = 18'h1; priv_kernel = 0;
    @(negedge clk);
    chk("R6 fault on user write", 64'(prot_fault), 64'd1);
    step();
    idle();
    look("R6 user write ignored", 20'h00300, 0, 12'h0, 0, '0);
    do_wr(20'h0, 18'h0, 0, 0, 1);
    look("R6 user flush ignored", 20'h00100, 0, 12'h0, 1, 18'h03000);

    // R10: kernel flush beats a simultaneous write
    do_wr(20'h00400, 18'h00004, 1, 1, 1);
    look("R10 flushed", 20'h00100, 0, 12'h0, 0, '0);
    look("R10 write discarded", 20'h00400, 0, 12'h0, 0, '0);

    // R9: reset mid-run
    do_wr(20'h00500, 18'h00005, 1, 1, 0);
    look("R9 before reset", 20'h00500, 0, 12'h0, 1, 18'h00005);
    rst_n = 0;
    step();
    rst_n = 1;
    step();
    look("R9 after reset", 20'h00500, 0, 12'h0, 0, '0);

    // random traffic, compared every cycle (R1..R11)
    for (int c = 0; c < 4000; c++) begin
      lk_valid    = ($urandom_range(0, 3) != 0);
      lk_prefetch = ($urandom_range(0, 9) < 3);
      lk_vpn      = 20'h00100 + 20'($urandom_range(0, 13));
      lk_off      = 12'($urandom_range(0, 4095));
      priv_kernel = ($urandom_range(0, 3) != 0);
      wr_en       = ($urandom_range(0, 3) == 0);
      wr_vpn      = 20'h00100 + 20'($urandom_range(0, 13));
      wr_ppn      = 18'($urandom_range(0, 262143));
      flush       = ($urandom_range(0, 99) < 2);
      step();
    end
    idle();
    step();

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule